// File: doc/BRIEF.md
# Programmable Edge Interrupt Detector

This block watches a set of external request lines and gives each line a one-clock request pulse when that line shows the edge it is set up to catch. Each line can be set to react to a falling edge, a rising edge, or both edges. One code value is reserved, and a line with that code never raises a request. The line's 2-bit edge code sits in a shared control byte. Software can write that byte whole, or set and clear one bit of it at a time, and can always read all of it back.

Each line passes through a multi-flop synchronizer before edge detection. A per-line enable acts as the switch that hands a pin to this function. While the enable is low, the line raises nothing. When the enable is switched on, the level the line holds at that moment is taken as the baseline, so a level that changed while the line was off, or in the same cycle as the switch, produces no request. Rewriting an edge code also produces no request by itself. Only a real transition that reaches the detector afterwards counts.

Top module: `edge_irq_detect`

## Requirements
- R1: After reset the control byte reads 0x00 (every line in falling-edge mode) and no request is raised.
- R2: A byte write (`cfg_wr`) loads `cfg_wdata` into the control byte, and the new value appears on `cfg_rdata` from the next clock.
- R3: A bit write (`bit_wr`) sets bit `bit_idx` of the control byte to `bit_val` and leaves every other bit unchanged. When a byte write and a bit write arrive in the same cycle, the byte write takes effect and the bit write is dropped.
- R4: Line i takes its edge code from control bits [2i+1:2i]. Code 00 raises a request on a high-to-low transition only.
- R5: Code 01 raises a request on a low-to-high transition only.
- R6: Code 11 raises a request on both transitions.
- R7: Code 10 is reserved, and a line holding it raises no request on any transition.
- R8: A qualifying transition on `pin_in[i]`, driven between clock edges, makes `irq[i]` high for exactly one clock. The pulse is high between the third and fourth rising clock edges that follow the transition.
- R9: While `pin_en[i]` is low, `irq[i]` stays low whatever `pin_in[i]` does.
- R10: When `pin_en[i]` goes high, no request results from a level change that happened while the line was disabled, or that reaches the detector in the same cycle as the switch-on.
- R11: Each line uses only its own edge code. Lines holding different codes respond independently to transitions that happen at the same time.
- R12: Changing a line's edge code while its input is steady raises no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Byte write strobe for the control byte |
| cfg_wdata | input | 8 | Byte write data |
| bit_wr | input | 1 | Single-bit write strobe |
| bit_idx | input | 3 | Index of the bit to write |
| bit_val | input | 1 | Value written to the indexed bit |
| cfg_rdata | output | 8 | Current control byte |
| pin_en | input | 4 | Per-line pin-function enable |
| pin_in | input | 4 | Asynchronous request lines |
| irq | output | 4 | One-clock request pulse per line |

## Verification
Register writes show on `cfg_rdata` one clock after the strobe. A pin transition reaches `irq` three rising edges later: two synchronizer flops, then the registered pulse. The bench changes inputs on falling clock edges and samples on falling edges. For every transition it checks the five falling edges that follow, and expects the pulse only in the third of them and nothing in the others. The enable-timing check arms `pin_en` exactly in the cycle the new level leaves the second synchronizer flop, which is the one cycle in which gating is needed.

// File: rtl/edge_irq_pkg.sv
package edge_irq_pkg;

   typedef enum logic [1:0] {
      EDGE_FALL = 2'b00,
      EDGE_RISE = 2'b01,
      EDGE_RSVD = 2'b10,
      EDGE_BOTH = 2'b11
   } edge_code_e;

   localparam int EDGE_CODE_W = 2;

   // Decide whether a prev->cur sample pair matches the selected edge.
   function automatic logic edge_match(input edge_code_e code,
                                       input logic prev_lvl,
                                       input logic cur_lvl);
      logic went_up;
      logic went_dn;
      went_up = cur_lvl & ~prev_lvl;
      went_dn = ~cur_lvl & prev_lvl;
      case (code)
         EDGE_FALL: edge_match = went_dn;
         EDGE_RISE: edge_match = went_up;
         EDGE_BOTH: edge_match = went_up | went_dn;
         default:   edge_match = 1'b0;
      endcase
   endfunction

endpackage

// File: rtl/edge_cfg_reg.sv
module edge_cfg_reg #(
   parameter int REG_W = 8,
   parameter int SEL_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             byte_we,
   input  logic [REG_W-1:0] byte_wdata,
   input  logic             bit_we,
   input  logic [SEL_W-1:0] bit_sel,
   input  logic             bit_wval,
   output logic [REG_W-1:0] cfg_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= '0;
      end else if (byte_we) begin
         cfg_q <= byte_wdata;
      end else if (bit_we && (int'(bit_sel) < REG_W)) begin
         cfg_q[bit_sel] <= bit_wval;
      end
   end

endmodule

// File: rtl/edge_sync.sv
module edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], d};
   end

   assign q = chain_q[STAGES-1];

endmodule

// File: rtl/edge_det_lane.sv
module edge_det_lane
   import edge_irq_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       lvl,
   input  logic       en,
   input  logic [1:0] code,
   output logic       pulse
);

   logic prev_lvl_q;
   logic en_d_q;
   logic hit;

   // prev always follows the synchronized level, so at switch-on it already
   // holds the current level; en_d_q masks the switch-on cycle itself.
   assign hit = en & en_d_q & edge_match(edge_code_e'(code), prev_lvl_q, lvl);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_lvl_q <= 1'b0;
         en_d_q     <= 1'b0;
         pulse      <= 1'b0;
      end else begin
         prev_lvl_q <= lvl;
         en_d_q     <= en;
         pulse      <= hit;
      end
   end

endmodule

// File: rtl/edge_irq_detect.sv
module edge_irq_detect #(
   parameter  int N_IN        = 4,
   parameter  int SYNC_STAGES = 2,
   localparam int REG_W       = N_IN * edge_irq_pkg::EDGE_CODE_W,
   localparam int SEL_W       = (REG_W > 1) ? $clog2(REG_W) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_wr,
   input  logic [REG_W-1:0] cfg_wdata,
   input  logic             bit_wr,
   input  logic [SEL_W-1:0] bit_idx,
   input  logic             bit_val,
   output logic [REG_W-1:0] cfg_rdata,
   input  logic [N_IN-1:0]  pin_en,
   input  logic [N_IN-1:0]  pin_in,
   output logic [N_IN-1:0]  irq
);
   import edge_irq_pkg::*;

   if (N_IN < 1) begin : g_bad_n_in
      $error("edge_irq_detect: N_IN must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("edge_irq_detect: SYNC_STAGES must be at least 2");
   end

   logic [REG_W-1:0] cfg_q;
   logic [N_IN-1:0]  lvl_s;

   edge_cfg_reg #(
      .REG_W (REG_W),
      .SEL_W (SEL_W)
   ) u_cfg (
      .clk        (clk),
      .rst_n      (rst_n),
      .byte_we    (cfg_wr),
      .byte_wdata (cfg_wdata),
      .bit_we     (bit_wr),
      .bit_sel    (bit_idx),
      .bit_wval   (bit_val),
      .cfg_q      (cfg_q)
   );

   assign cfg_rdata = cfg_q;

   for (genvar i = 0; i < N_IN; i++) begin : g_lane
      edge_sync #(
         .STAGES (SYNC_STAGES)
      ) u_sync (
         .clk   (clk),
         .rst_n (rst_n),
         .d     (pin_in[i]),
         .q     (lvl_s[i])
      );

      edge_det_lane u_det (
         .clk   (clk),
         .rst_n (rst_n),
         .lvl   (lvl_s[i]),
         .en    (pin_en[i]),
         .code  (cfg_q[EDGE_CODE_W*i +: EDGE_CODE_W]),
         .pulse (irq[i])
      );
   end

endmodule

// File: rtl/edge_irq_chk.sv
module edge_irq_chk #(
   parameter int N_IN  = 4,
   parameter int REG_W = 8,
   parameter int SEL_W = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cfg_wr,
   input logic [REG_W-1:0] cfg_wdata,
   input logic             bit_wr,
   input logic [SEL_W-1:0] bit_idx,
   input logic             bit_val,
   input logic [REG_W-1:0] cfg_rdata,
   input logic [N_IN-1:0]  pin_en,
   input logic [N_IN-1:0]  irq
);

   // R2
   byte_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_wr |=> cfg_rdata == $past(cfg_wdata));

   // R3
   bit_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_wr && !cfg_wr && int'(bit_idx) < REG_W) |=> cfg_rdata[$past(bit_idx)] == $past(bit_val));

   // R3
   cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!bit_wr && !cfg_wr) |=> $stable(cfg_rdata));

   // R9
   disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq & ~$past(pin_en)) == '0);

   // R10
   arm_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq & ~$past(pin_en, 2)) == '0);

   for (genvar i = 0; i < N_IN; i++) begin : g_rsvd
      // R7
      rsvd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
         irq[i] |-> $past(cfg_rdata[2*i +: 2]) != 2'b10);
   end

endmodule

bind edge_irq_detect edge_irq_chk #(
   .N_IN  (N_IN),
   .REG_W (REG_W),
   .SEL_W (SEL_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cfg_wr    (cfg_wr),
   .cfg_wdata (cfg_wdata),
   .bit_wr    (bit_wr),
   .bit_idx   (bit_idx),
   .bit_val   (bit_val),
   .cfg_rdata (cfg_rdata),
   .pin_en    (pin_en),
   .irq       (irq)
);

// File: tb/edge_irq_detect_tb.sv
`timescale 1ns/1ps
module edge_irq_detect_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_wr = 1'b0;
   logic [7:0] cfg_wdata = '0;
   logic       bit_wr = 1'b0;
   logic [2:0] bit_idx = '0;
   logic       bit_val = 1'b0;
   logic [7:0] cfg_rdata;
   logic [3:0] pin_en = '0;
   logic [3:0] pin_in = '0;
   logic [3:0] irq;

   int n_checks = 0;
   int n_fails  = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   edge_irq_detect u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_wr    (cfg_wr),
      .cfg_wdata (cfg_wdata),
      .bit_wr    (bit_wr),
      .bit_idx   (bit_idx),
      .bit_val   (bit_val),
      .cfg_rdata (cfg_rdata),
      .pin_en    (pin_en),
      .pin_in    (pin_in),
      .irq       (irq)
   );

   // vector: {lane[1:0], code[1:0], from, to, expect}
   localparam int NVEC = 12;
   localparam logic [6:0] VEC [NVEC] = '{
      {2'd0, 2'b00, 1'b1, 1'b0, 1'b1},   // R4
      {2'd0, 2'b00, 1'b0, 1'b1, 1'b0},   // R4
      {2'd1, 2'b01, 1'b0, 1'b1, 1'b1},   // R5
      {2'd1, 2'b01, 1'b1, 1'b0, 1'b0},   // R5
      {2'd2, 2'b11, 1'b0, 1'b1, 1'b1},   // R6
      {2'd2, 2'b11, 1'b1, 1'b0, 1'b1},   // R6
      {2'd3, 2'b10, 1'b0, 1'b1, 1'b0},   // R7
      {2'd3, 2'b10, 1'b1, 1'b0, 1'b0},   // R7
      {2'd3, 2'b11, 1'b1, 1'b0, 1'b1},   // R6
      {2'd0, 2'b01, 1'b0, 1'b1, 1'b1},   // R5
      {2'd2, 2'b00, 1'b1, 1'b0, 1'b1},   // R4
      {2'd1, 2'b10, 1'b0, 1'b1, 1'b0}    // R7
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic byte_write(input logic [7:0] v);
      cfg_wr = 1'b1; cfg_wdata = v;
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   task automatic bit_write(input logic [2:0] idx, input logic v);
      bit_wr = 1'b1; bit_idx = idx; bit_val = v;
      @(negedge clk);
      bit_wr = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask

   task automatic expect_quiet(input string req, input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         check(req, 32'(irq), 32'h0);
      end
   endtask

   // after pins change at a negedge: pulse due at the 3rd following negedge (R8)
   task automatic expect_window(input string req, input logic [3:0] due);
      for (int k = 1; k <= 5; k++) begin
         @(negedge clk);
         check(req, 32'(irq), (k == 3) ? 32'(due) : 32'h0);
      end
   endtask

   initial begin
      for (int c = 0; c < 100000 && !finished; c++) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog actual=timeout expected=done");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      idle(3);
      // R1 reset state
      check("R1 cfg", 32'(cfg_rdata), 32'h00);
      check("R1 irq", 32'(irq), 32'h0);
      rst_n = 1'b1;
      idle(2);
      check("R1 cfg after release", 32'(cfg_rdata), 32'h00);

      // R2 byte write
      byte_write(8'hA5);
      check("R2", 32'(cfg_rdata), 32'hA5);
      // R3 bit writes
      bit_write(3'd1, 1'b1);
      check("R3 set bit1", 32'(cfg_rdata), 32'hA7);
      bit_write(3'd7, 1'b0);
      check("R3 clear bit7", 32'(cfg_rdata), 32'h27);
      cfg_wr = 1'b1; cfg_wdata = 8'h3C; bit_wr = 1'b1; bit_idx = 3'd0; bit_val = 1'b1;
      @(negedge clk);
      cfg_wr = 1'b0; bit_wr = 1'b0;
      check("R3 byte wins", 32'(cfg_rdata), 32'h3C);

      // table walk: R4 R5 R6 R7 R8
      foreach (VEC[v]) begin
         logic [1:0] ln;
         ln = VEC[v][6:5];
         pin_en = '0;
         byte_write(8'(VEC[v][4:3]) << (2 * ln));
         pin_in = '0;
         pin_in[ln] = VEC[v][2];
         idle(4);
         pin_en = 4'hF;
         idle(2);
         pin_in[ln] = VEC[v][1];
         expect_window("R8 vector", VEC[v][0] ? (4'b0001 << ln) : 4'b0000);
      end

      // R9 disabled lines stay quiet
      pin_en = '0;
      pin_in = '0;
      byte_write(8'hFF);
      idle(4);
      pin_in = 4'hF;
      expect_quiet("R9 rise", 5);
      pin_in = 4'h0;
      expect_quiet("R9 fall", 5);

      // R10 change while disabled, then switch on
      pin_in = 4'hF;
      idle(5);
      pin_en = 4'hF;
      expect_quiet("R10 late enable", 5);
      // R10 switch on in the cycle the new level reaches the detector
      pin_en = '0;
      idle(2);
      pin_in = 4'h0;
      idle(2);
      pin_en = 4'hF;
      expect_quiet("R10 same-cycle enable", 5);

      // R12 code changes with steady inputs
      pin_in = 4'hF;
      idle(5);
      byte_write(8'h00);
      check("R12 pulse", 32'(irq), 32'h0);
      byte_write(8'h55);
      check("R12 pulse", 32'(irq), 32'h0);
      byte_write(8'hFF);
      expect_quiet("R12", 4);

      // R11 independence: lane3=11 lane2=10 lane1=01 lane0=00
      pin_en = '0;
      byte_write(8'b11_10_01_00);
      pin_in = 4'h0;
      idle(5);
      pin_en = 4'hF;
      idle(2);
      pin_in = 4'hF;
      expect_window("R11 rise", 4'b1010);
      pin_in = 4'h0;
      expect_window("R11 fall", 4'b1001);

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

endmodule